// File: doc/BRIEF.md
# Programmable UART Baud Generator

This block turns a slow input clock into the sixteen-times-oversampling tick that a UART receiver and transmitter run from. The divisor is 16 bits wide. It is written one byte at a time through a small register write port, and a select input picks the low or the high byte. The block has a down-counter that runs once per divisor period. It drives its output low at the end of each period and high for the rest.

Every divisor write loads the counter at once. A new rate therefore starts on the next input clock, without waiting for a long old count to finish. Three small divisors have their own output shapes:

- A divisor of 0 divides the clock by three.
- A divisor of 1 passes the inverted input clock straight to the output.
- A divisor of 2 gives a square wave at half the input rate.

Any larger divisor gives a low pulse two input clocks wide in every period. After reset the output stays high until the first divisor write starts the counter.

Top module: `baudgen`

## Requirements
- R1: The divisor is {high byte, low byte}. A write with `wr_sel_i`=0 replaces the low byte (bits 7:0) and a write with `wr_sel_i`=1 replaces the high byte (bits 15:8). The other byte keeps its value.
- R2: With no write in between, the output repeats with a period, in input clocks, equal to the divisor for divisors of 2 or more and equal to 3 for a divisor of 0.
- R3: A write loads the counter on the same clock edge. In the first cycle after a write of a divisor of 2 or more, or of 0, the output is high, and the new period starts there.
- R4: With a divisor of 0 the output is low for exactly one input clock out of every three, in the last cycle of each period.
- R5: With a divisor of 1 the output is the inverse of the input clock: low while `clk_i` is high and high while it is low.
- R6: With a divisor of 2 the output toggles on every input clock (50% duty).
- R7: With a divisor N of 3 or more the output is low for the last 2 input clocks of each N-clock period and high for the other N-2.
- R8: Reset clears both divisor bytes and the counter. From reset until the first divisor write the output stays high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Input clock to be divided |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Divisor byte write strobe |
| wr_sel_i | input | 1 | Byte select: 0 low byte, 1 high byte |
| wr_data_i | input | 8 | Byte to write |
| baud16_o | output | 1 | Divided output at sixteen times the baud rate |

## Verification
On every cycle the assertions check several things:

- the byte placement and retention of writes;
- the counter load on a write and the range the counter stays in while running;
- the idle-high output before the first write;
- the toggling at divisor 2, the single low cycle at divisor 0 and the two-cycle low pulse at larger divisors.

The output at divisor 1 follows the clock level within a cycle, so only the bench's samples at both clock phases can show it. The same holds for the full period length and the low/high ratio over whole periods. The restart in the middle of a count, and the return to idle after a reset in the middle of a run, also need the bench's scenarios.

// File: rtl/baudgen_pkg.sv
package baudgen_pkg;
  typedef enum logic [1:0] {
    MODE_DIV3   = 2'd0,  // divisor 0
    MODE_FOLLOW = 2'd1,  // divisor 1: inverted input clock
    MODE_HALF   = 2'd2,  // divisor 2
    MODE_WIDE   = 2'd3   // divisor >= 3
  } bg_mode_e;

  localparam int unsigned LOW_SPAN    = 2;  // low cycles in wide mode
  localparam int unsigned ZERO_PERIOD = 3;  // period for divisor 0
endpackage

// File: rtl/baudgen_latch.sv
module baudgen_latch #(
  parameter int unsigned BYTE_W = 8,
  parameter int unsigned NBYTES = 2,
  localparam int unsigned DIV_W = BYTE_W * NBYTES,
  localparam int unsigned SEL_W = (NBYTES > 1) ? $clog2(NBYTES) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [SEL_W-1:0]  wr_sel_i,
  input  logic [BYTE_W-1:0] wr_data_i,
  output logic [DIV_W-1:0]  div_o,
  output logic [DIV_W-1:0]  next_div_o
);
  for (genvar b = 0; b < NBYTES; b++) begin : g_byte
    logic [BYTE_W-1:0] q;
    logic              hit;
    assign hit = wr_en_i && (wr_sel_i == SEL_W'(b));

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)  q <= '0;
      else if (hit) q <= wr_data_i;
    end

    assign div_o[b*BYTE_W +: BYTE_W]      = q;
    // value the divisor takes at this edge, used for the immediate reload
    assign next_div_o[b*BYTE_W +: BYTE_W] = hit ? wr_data_i : q;
  end
endmodule

// File: rtl/baudgen_counter.sv
module baudgen_counter #(
  parameter int unsigned DIV_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [DIV_W-1:0] load_val_i,
  input  logic [DIV_W-1:0] reload_val_i,
  output logic [DIV_W-1:0] cnt_o,
  output logic             run_o
);
  logic [DIV_W-1:0] cnt_q;
  logic             run_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      run_q <= 1'b0;
    end else if (load_i) begin
      cnt_q <= load_val_i;
      run_q <= 1'b1;
    end else if (run_q) begin
      cnt_q <= (cnt_q <= DIV_W'(1)) ? reload_val_i : cnt_q - DIV_W'(1);
    end
  end

  assign cnt_o = cnt_q;
  assign run_o = run_q;
endmodule

// File: rtl/baudgen_shaper.sv
module baudgen_shaper
  import baudgen_pkg::*;
#(
  parameter int unsigned DIV_W = 16
) (
  input  logic             clk_i,
  input  logic             run_i,
  input  bg_mode_e         mode_i,
  input  logic [DIV_W-1:0] cnt_i,
  output logic             out_o
);
  logic last_one;
  logic last_span;

  assign last_one  = (cnt_i == DIV_W'(1));
  assign last_span = (cnt_i != '0) && (cnt_i <= DIV_W'(LOW_SPAN));

  always_comb begin
    if (!run_i) begin
      out_o = 1'b1;
    end else begin
      unique case (mode_i)
        MODE_FOLLOW: out_o = ~clk_i;
        MODE_WIDE:   out_o = ~last_span;
        default:     out_o = ~last_one;  // divisor 0 and 2
      endcase
    end
  end
endmodule

// File: rtl/baudgen.sv
module baudgen
  import baudgen_pkg::*;
#(
  parameter int unsigned BYTE_W = 8,
  parameter int unsigned NBYTES = 2,
  localparam int unsigned DIV_W = BYTE_W * NBYTES,
  localparam int unsigned SEL_W = (NBYTES > 1) ? $clog2(NBYTES) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [SEL_W-1:0]  wr_sel_i,
  input  logic [BYTE_W-1:0] wr_data_i,
  output logic              baud16_o
);
  logic [DIV_W-1:0] div_q;
  logic [DIV_W-1:0] next_div;
  logic [DIV_W-1:0] cnt_q;
  logic             run_q;
  bg_mode_e         mode;

  function automatic bg_mode_e mode_of(logic [DIV_W-1:0] d);
    if (d == '0)             return MODE_DIV3;
    else if (d == DIV_W'(1)) return MODE_FOLLOW;
    else if (d == DIV_W'(2)) return MODE_HALF;
    else                     return MODE_WIDE;
  endfunction

  function automatic logic [DIV_W-1:0] period_of(logic [DIV_W-1:0] d);
    return (d == '0) ? DIV_W'(ZERO_PERIOD) : d;
  endfunction

  baudgen_latch #(.BYTE_W(BYTE_W), .NBYTES(NBYTES)) i_latch (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .wr_en_i    (wr_en_i),
    .wr_sel_i   (wr_sel_i),
    .wr_data_i  (wr_data_i),
    .div_o      (div_q),
    .next_div_o (next_div)
  );

  baudgen_counter #(.DIV_W(DIV_W)) i_counter (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .load_i       (wr_en_i),
    .load_val_i   (period_of(next_div)),
    .reload_val_i (period_of(div_q)),
    .cnt_o        (cnt_q),
    .run_o        (run_q)
  );

  assign mode = mode_of(div_q);

  baudgen_shaper #(.DIV_W(DIV_W)) i_shaper (
    .clk_i  (clk_i),
    .run_i  (run_q),
    .mode_i (mode),
    .cnt_i  (cnt_q),
    .out_o  (baud16_o)
  );
endmodule

// File: rtl/baudgen_chk.sv
module baudgen_chk #(
  parameter int unsigned BYTE_W = 8,
  parameter int unsigned DIV_W  = 16,
  parameter int unsigned SEL_W  = 1
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              wr_en_i,
  input logic [SEL_W-1:0]  wr_sel_i,
  input logic [BYTE_W-1:0] wr_data_i,
  input logic              baud16_o,
  input logic [DIV_W-1:0]  div_i,
  input logic [DIV_W-1:0]  cnt_i,
  input logic              run_i
);
  // R1
  lo_byte_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i && wr_sel_i == '0 |=> div_i[BYTE_W-1:0] == $past(wr_data_i));
  // R1
  hi_keep_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i && wr_sel_i == '0 |=> div_i[DIV_W-1:BYTE_W] == $past(div_i[DIV_W-1:BYTE_W]));
  // R3
  reload_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i |=> run_i && cnt_i == ((div_i == '0) ? DIV_W'(3) : div_i));
  // R2
  cnt_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_i |-> cnt_i != '0 && cnt_i <= ((div_i < DIV_W'(3)) ? DIV_W'(3) : div_i));
  // R8
  idle_high_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run_i |-> baud16_o);
  // R6
  half_toggle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_i && div_i == DIV_W'(2) && !wr_en_i |=> baud16_o != $past(baud16_o));
  // R4
  div3_single_low_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_i && div_i == '0 && !baud16_o && !wr_en_i |=> baud16_o);
  // R7
  wide_pair_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_i && div_i >= DIV_W'(3) && !wr_en_i && $fell(baud16_o) |=> !baud16_o);
endmodule

bind baudgen baudgen_chk #(.BYTE_W(BYTE_W), .DIV_W(DIV_W), .SEL_W(SEL_W)) i_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .wr_en_i   (wr_en_i),
  .wr_sel_i  (wr_sel_i),
  .wr_data_i (wr_data_i),
  .baud16_o  (baud16_o),
  .div_i     (div_q),
  .cnt_i     (cnt_q),
  .run_i     (run_q)
);

// File: tb/test_baudgen.sv
`timescale 1ns/1ps
module test_baudgen;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       wr_en_i = 1'b0;
  logic [0:0] wr_sel_i = '0;
  logic [7:0] wr_data_i = '0;
  logic       baud16_o;

  int errors = 0;
  int checks = 0;

  // reference model state
  int  m_lo = 0, m_hi = 0, m_div = 0, m_cnt = 0;
  bit  m_run = 0, m_just_wr = 0;
  // period measurement
  int  since_rise = 0;
  bit  seen_rise = 0;
  bit  prev_out = 1;

  baudgen i_baudgen (
    .clk_i(clk_i), .rst_ni(rst_ni), .wr_en_i(wr_en_i),
    .wr_sel_i(wr_sel_i), .wr_data_i(wr_data_i), .baud16_o(baud16_o)
  );

  always #10 clk_i = ~clk_i;  // 50 MHz

  function automatic int period_of(int d);
    return (d == 0) ? 3 : d;
  endfunction

  always @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      m_lo = 0; m_hi = 0; m_div = 0; m_cnt = 0; m_run = 0; m_just_wr = 0;
    end else if (wr_en_i) begin
      if (wr_sel_i == 1'b0) m_lo = wr_data_i; else m_hi = wr_data_i;
      m_div = m_hi * 256 + m_lo;
      m_cnt = period_of(m_div);
      m_run = 1;
      m_just_wr = 1;
    end else begin
      m_just_wr = 0;
      if (m_run) m_cnt = (m_cnt <= 1) ? period_of(m_div) : m_cnt - 1;
    end
  end

  function automatic bit expect_out(bit clk_level);
    if (!m_run) return 1'b1;
    if (m_div == 1) return !clk_level;
    if (m_div >= 3) return !(m_cnt <= 2);
    return !(m_cnt == 1);
  endfunction

  function automatic string tag_now();
    if (!m_run) return "R8";
    if (m_just_wr) return "R3";
    if (m_div > 255) return "R1";
    if (m_div == 0) return "R4";
    if (m_div == 1) return "R5";
    if (m_div == 2) return "R6";
    return "R7";
  endfunction

  task automatic check(string req, int act, int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  always @(posedge clk_i) begin
    #5;
    check(tag_now(), baud16_o, expect_out(1'b1));
    if (m_just_wr) begin
      seen_rise = 0;
      since_rise = 0;
    end else if (m_run && m_div != 1) begin
      since_rise++;
      if (baud16_o && !prev_out) begin
        if (seen_rise) check("R2", since_rise, period_of(m_div));
        seen_rise = 1;
        since_rise = 0;
      end
    end
    prev_out = baud16_o;
    #10;
    if (m_run && m_div == 1) check("R5", baud16_o, expect_out(1'b0));
  end

  task automatic wr(bit sel, int data);
    @(negedge clk_i);
    wr_en_i = 1'b1; wr_sel_i = sel; wr_data_i = data[7:0];
    @(negedge clk_i);
    wr_en_i = 1'b0;
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk_i);
  endtask

  initial begin
    #1;
    check("R8", baud16_o, 1);  // reset: idle high
    idle(3);
    rst_ni = 1'b1;
    idle(6);                   // R8: no write, stays high
    wr(1'b0, 5);  idle(20);    // R7 divisor 5
    wr(1'b0, 0);  idle(15);    // R4 divisor 0
    wr(1'b0, 1);  idle(10);    // R5
    wr(1'b0, 2);  idle(10);    // R6
    wr(1'b0, 3);  idle(12);    // R7 minimum wide
    wr(1'b1, 1);  idle(600);   // R1 divisor 0x103
    wr(1'b0, 40); idle(10);    // R1 0x128, then mid-count restart
    wr(1'b1, 0);  idle(5);     // R3 reload to 40
    wr(1'b0, 7);  idle(25);    // R3 restart with 7
    wr(1'b0, 9); wr(1'b0, 4); idle(15);  // back-to-back writes
    @(negedge clk_i); rst_ni = 1'b0;
    idle(2);
    rst_ni = 1'b1;
    idle(8);                   // R8 idle after reset
    wr(1'b0, 6);  idle(20);    // R1 low byte only after reset
    idle(2);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(20 * 100000);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule